// File: doc/BRIEF.md
# Exception Entry Vector Generator

This block is the general-exception entry logic of a 32-bit processor's system-control coprocessor. The pipeline sends it one exception request. The request carries a 5-bit cause code, the faulting PC, a flag for an instruction in a branch delay slot, and the number of the coprocessor at fault. On that request the block does three things:

- It captures the restart address in the return-PC register.
- It records the cause in the cause fields.
- It raises the exception-level flag.

One cycle later the block presents the handler address on a registered redirect port. The fetch stage is expected to jump there.

The handler address is a base plus an offset. The base is either a fixed boot window or a programmable vector base. Which one is used is chosen by the boot-vector flag. The offset depends on three things: whether the request is a translation refill miss, whether it is an interrupt, and the current values of the exception-level flag and the dedicated-interrupt-vector flag. The block also has simple write ports for the status flags, the dedicated-interrupt-vector flag and the vector base. Software uses them to set these values up and to leave the handler.

Top module: `exc_vector_gen`

## Requirements
- R1: After reset, the return PC, the slot flag, the cause code, the coprocessor field, the dedicated-interrupt-vector flag and the exception-level flag are all 0. The boot-vector flag is 1, the vector base reads 0x8000_0000, and redir_valid is low.
- R2: When an exception is accepted with the exception-level flag at 0 and exc_in_slot at 0, ret_pc becomes exc_pc and cs_in_slot becomes 0.
- R3: When an exception is accepted with the exception-level flag at 0 and exc_in_slot at 1, ret_pc becomes exc_pc minus 4 and cs_in_slot becomes 1.
- R4: When an exception is accepted with the exception-level flag already at 1, ret_pc and cs_in_slot keep their values.
- R5: The vector offset is chosen from the exception-level flag, the request type and the dedicated-interrupt-vector flag:
  - 0x000 for a refill miss (exc_refill=1) with the exception-level flag at 0.
  - 0x200 for an interrupt (exc_type code 0) when the dedicated-interrupt-vector flag is 1 and the exception-level flag is 0.
  - 0x180 in every other case, including a refill miss taken with the exception-level flag at 1.
- R6: With the boot-vector flag at 1, redir_pc is 0xBFC0_0200 plus the offset. With the flag at 0, redir_pc is the vector base plus the offset. Both flags are taken as they stood before the exception.
- R7: Every accepted exception loads cs_code with exc_type and cs_cop with exc_cop, and sets the exception-level flag. The code sits in bits 6:2 of the cause word; the value 0 means interrupt.
- R8: The vector base has a fixed layout:
  - Bits 31:30 always read 2'b10.
  - Bits 11:0 always read 0.
  - Only bits 29:12 take written data.
  - A write to it while the boot-vector flag is 0 is ignored.
- R9: redir_valid is high for exactly one cycle, in the cycle after each accepted request, and redir_pc is registered with it.
- R10: Status or cause-flag writes presented in the same cycle as an exception request are dropped. The exception's own update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request, one cycle per exception |
| exc_type | input | 5 | Cause code of the exception (0 = interrupt) |
| exc_refill | input | 1 | Request is a translation refill miss |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| exc_cop | input | 2 | Faulting coprocessor number |
| st_wr_en | input | 1 | Write enable for the two status flags |
| st_wr_boot | input | 1 | New boot-vector flag value |
| st_wr_level | input | 1 | New exception-level flag value |
| cs_wr_en | input | 1 | Write enable for the dedicated-interrupt-vector flag |
| cs_wr_ivec | input | 1 | New dedicated-interrupt-vector flag value |
| vb_wr_en | input | 1 | Vector base write enable |
| vb_wr_data | input | 32 | Vector base write data |
| ret_pc | output | 32 | Return PC register |
| cs_in_slot | output | 1 | Cause: exception came from a delay slot |
| cs_cop | output | 2 | Cause: coprocessor number |
| cs_code | output | 5 | Cause: exception code |
| cs_ivec | output | 1 | Cause: dedicated interrupt vector enable |
| st_level | output | 1 | Status: exception-level flag |
| st_boot | output | 1 | Status: boot-vector flag |
| vec_base | output | 32 | Programmable vector base |
| redir_valid | output | 1 | Redirect strobe |
| redir_pc | output | 32 | Handler address |

## Verification
The bench targets the places where the offset rules interact:

- A refill miss taken at exception level must fall back to 0x180. A design that ignored the level flag would send a nested miss to the fast refill entry.
- An interrupt with the dedicated vector enabled but at exception level must also use 0x180. A non-interrupt code with the dedicated vector enabled must not move.

It also covers the state that must hold or be dropped:

- A nested exception must leave the return PC and slot flag frozen. A wrong design would overwrite the address software needs to resume.
- A delay-slot fault must store the branch address, not the slot address.
- A vector-base write under the programmable window, and status writes racing an exception, must leave no trace. A wrong design would show up as a moved handler address or a cleared level flag.

// File: rtl/exc_vec_pkg.sv
`timescale 1ns/1ps
package exc_vec_pkg;

   // Which of the three entry offsets was chosen for a request
   typedef enum logic [1:0] {
      EV_OFS_REFILL  = 2'd0,
      EV_OFS_GENERAL = 2'd1,
      EV_OFS_INTR    = 2'd2
   } ev_ofs_e;

   // Build a mask with ones on bits [hi:lo] of a width-w vector
   function automatic logic [63:0] ev_field_mask(input int unsigned hi, input int unsigned lo);
      logic [63:0] m;
      m = '0;
      for (int unsigned i = 0; i < 64; i++) begin
         if (i >= lo && i <= hi) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/exc_vec_offset_sel.sv
`timescale 1ns/1ps
module exc_vec_offset_sel
   import exc_vec_pkg::*;
#(
   parameter int unsigned          OFS_W       = 12,
   parameter logic [OFS_W-1:0]     OFS_REFILL  = 'h000,
   parameter logic [OFS_W-1:0]     OFS_GENERAL = 'h180,
   parameter logic [OFS_W-1:0]     OFS_INTR    = 'h200,
   parameter bit                   HAS_IVEC    = 1'b1
) (
   input  logic             is_intr,
   input  logic             refill,
   input  logic             level,
   input  logic             ivec,
   output ev_ofs_e          sel,
   output logic [OFS_W-1:0] offset
);

   logic intr_dedicated;

   generate
      if (HAS_IVEC) begin : g_ivec
         // dedicated interrupt entry only applies outside exception level
         assign intr_dedicated = is_intr & ivec & ~level;
      end else begin : g_no_ivec
         logic unused_ivec;
         assign unused_ivec    = is_intr ^ ivec;
         assign intr_dedicated = 1'b0;
      end
   endgenerate

   always_comb begin
      if (refill && !level) begin
         sel = EV_OFS_REFILL;
      end else if (intr_dedicated) begin
         sel = EV_OFS_INTR;
      end else begin
         sel = EV_OFS_GENERAL;
      end
   end

   always_comb begin
      unique case (sel)
         EV_OFS_REFILL: offset = OFS_REFILL;
         EV_OFS_INTR:   offset = OFS_INTR;
         default:       offset = OFS_GENERAL;
      endcase
   end

endmodule

// File: rtl/exc_vec_base_sel.sv
`timescale 1ns/1ps
module exc_vec_base_sel
   import exc_vec_pkg::*;
#(
   parameter int unsigned        XLEN      = 32,
   parameter int unsigned        PAGE_LSB  = 12,
   parameter int unsigned        FIX_W     = 2,
   parameter logic [FIX_W-1:0]   FIX_VAL   = 2'b10,
   parameter logic [XLEN-1:0]    BOOT_BASE = 32'hBFC0_0200,
   parameter logic [XLEN-1:0]    BASE_RST  = 32'h8000_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            boot,
   input  logic            wr_en,
   input  logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] vbase,
   output logic [XLEN-1:0] base
);

   localparam int unsigned  RW_HI    = XLEN - FIX_W - 1;
   localparam logic [63:0]  MASK64   = ev_field_mask(RW_HI, PAGE_LSB);
   localparam logic [XLEN-1:0] RW_MASK  = MASK64[XLEN-1:0];
   localparam logic [XLEN-1:0] FIX_BITS = {FIX_VAL, {(XLEN-FIX_W){1'b0}}};

   generate
      if (PAGE_LSB >= XLEN - FIX_W) begin : g_bad_layout
         $error("exc_vec_base_sel: no writable vector base bits");
      end
      if (BASE_RST[XLEN-1 -: FIX_W] != FIX_VAL) begin : g_bad_rst
         $error("exc_vec_base_sel: reset base disagrees with fixed bits");
      end
   endgenerate

   logic            wr_ok;
   logic [XLEN-1:0] vbase_q;

   // base writes only while the boot window is in use
   assign wr_ok = wr_en & boot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vbase_q <= (BASE_RST & RW_MASK) | FIX_BITS;
      end else if (wr_ok) begin
         vbase_q <= (wr_data & RW_MASK) | FIX_BITS;
      end
   end

   assign vbase = vbase_q;
   assign base  = boot ? BOOT_BASE : vbase_q;

endmodule

// File: rtl/exc_vec_state.sv
`timescale 1ns/1ps
module exc_vec_state #(
   parameter int unsigned     XLEN       = 32,
   parameter int unsigned     CE_W       = 2,
   parameter int unsigned     CODE_W     = 5,
   parameter int unsigned     INSN_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              in_slot,
   input  logic [XLEN-1:0]   pc,
   input  logic [CE_W-1:0]   cop,
   input  logic [CODE_W-1:0] code,
   input  logic              st_wr_en,
   input  logic              st_wr_boot,
   input  logic              st_wr_level,
   input  logic              cs_wr_en,
   input  logic              cs_wr_ivec,
   output logic [XLEN-1:0]   ret_pc,
   output logic              cs_in_slot,
   output logic [CE_W-1:0]   cs_cop,
   output logic [CODE_W-1:0] cs_code,
   output logic              cs_ivec,
   output logic              st_level,
   output logic              st_boot
);

   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   logic [XLEN-1:0] restart_pc;
   assign restart_pc = in_slot ? (pc - STEP) : pc;

   // return address and slot flag: frozen while already at exception level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_pc     <= '0;
         cs_in_slot <= 1'b0;
      end else if (take && !st_level) begin
         ret_pc     <= restart_pc;
         cs_in_slot <= in_slot;
      end
   end

   // cause code and coprocessor: loaded by every exception
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_cop  <= '0;
         cs_code <= '0;
      end else if (take) begin
         cs_cop  <= cop;
         cs_code <= code;
      end
   end

   // status flags: an exception overrides any software write that cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_level <= 1'b0;
         st_boot  <= 1'b1;
      end else if (take) begin
         st_level <= 1'b1;
      end else if (st_wr_en) begin
         st_level <= st_wr_level;
         st_boot  <= st_wr_boot;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_ivec <= 1'b0;
      end else if (cs_wr_en && !take) begin
         cs_ivec <= cs_wr_ivec;
      end
   end

endmodule

// File: rtl/exc_vector_gen.sv
`timescale 1ns/1ps
module exc_vector_gen
   import exc_vec_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned CE_W      = 2,
   parameter int unsigned CODE_W    = 5,
   parameter int unsigned OFS_W     = 12,
   parameter bit          HAS_IVEC  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_req,
   input  logic [CODE_W-1:0] exc_type,
   input  logic              exc_refill,
   input  logic [XLEN-1:0]   exc_pc,
   input  logic              exc_in_slot,
   input  logic [CE_W-1:0]   exc_cop,
   input  logic              st_wr_en,
   input  logic              st_wr_boot,
   input  logic              st_wr_level,
   input  logic              cs_wr_en,
   input  logic              cs_wr_ivec,
   input  logic              vb_wr_en,
   input  logic [XLEN-1:0]   vb_wr_data,
   output logic [XLEN-1:0]   ret_pc,
   output logic              cs_in_slot,
   output logic [CE_W-1:0]   cs_cop,
   output logic [CODE_W-1:0] cs_code,
   output logic              cs_ivec,
   output logic              st_level,
   output logic              st_boot,
   output logic [XLEN-1:0]   vec_base,
   output logic              redir_valid,
   output logic [XLEN-1:0]   redir_pc
);

   localparam logic [CODE_W-1:0] CODE_INTR = '0;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("exc_vector_gen: only a 32-bit datapath is supported");
      end
      if (OFS_W >= XLEN) begin : g_bad_ofs
         $error("exc_vector_gen: offset wider than address");
      end
   endgenerate

   ev_ofs_e          ofs_sel;
   logic [OFS_W-1:0] offset;
   logic [XLEN-1:0]  base;
   logic [XLEN-1:0]  target;
   logic             is_intr;

   assign is_intr = (exc_type == CODE_INTR);

   exc_vec_offset_sel #(
      .OFS_W    (OFS_W),
      .HAS_IVEC (HAS_IVEC)
   ) u_ofs (
      .is_intr (is_intr),
      .refill  (exc_refill),
      .level   (st_level),
      .ivec    (cs_ivec),
      .sel     (ofs_sel),
      .offset  (offset)
   );

   exc_vec_base_sel #(
      .XLEN (XLEN)
   ) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .boot    (st_boot),
      .wr_en   (vb_wr_en),
      .wr_data (vb_wr_data),
      .vbase   (vec_base),
      .base    (base)
   );

   exc_vec_state #(
      .XLEN   (XLEN),
      .CE_W   (CE_W),
      .CODE_W (CODE_W)
   ) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (exc_req),
      .in_slot     (exc_in_slot),
      .pc          (exc_pc),
      .cop         (exc_cop),
      .code        (exc_type),
      .st_wr_en    (st_wr_en),
      .st_wr_boot  (st_wr_boot),
      .st_wr_level (st_wr_level),
      .cs_wr_en    (cs_wr_en),
      .cs_wr_ivec  (cs_wr_ivec),
      .ret_pc      (ret_pc),
      .cs_in_slot  (cs_in_slot),
      .cs_cop      (cs_cop),
      .cs_code     (cs_code),
      .cs_ivec     (cs_ivec),
      .st_level    (st_level),
      .st_boot     (st_boot)
   );

   logic unused_sel;
   assign unused_sel = ^ofs_sel;

   assign target = base + XLEN'(offset);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redir_valid <= 1'b0;
         redir_pc    <= '0;
      end else begin
         redir_valid <= exc_req;
         if (exc_req) redir_pc <= target;
      end
   end

endmodule

// File: rtl/exc_vec_chk.sv
`timescale 1ns/1ps
module exc_vec_chk #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned CE_W   = 2,
   parameter int unsigned CODE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exc_req,
   input logic [CODE_W-1:0] exc_type,
   input logic [XLEN-1:0]   exc_pc,
   input logic              exc_in_slot,
   input logic [CE_W-1:0]   exc_cop,
   input logic [XLEN-1:0]   ret_pc,
   input logic              cs_in_slot,
   input logic [CE_W-1:0]   cs_cop,
   input logic [CODE_W-1:0] cs_code,
   input logic              cs_ivec,
   input logic              st_level,
   input logic              st_boot,
   input logic [XLEN-1:0]   vec_base,
   input logic              redir_valid
);

   a_r9_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> redir_valid);

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |=> !redir_valid);

   a_r7_cause_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> st_level && cs_code == $past(exc_type) && cs_cop == $past(exc_cop));

   a_r4_nested_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && st_level |=> $stable(ret_pc) && $stable(cs_in_slot));

   a_r3_slot_restart: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && !st_level && exc_in_slot |=> cs_in_slot && ret_pc == $past(exc_pc) - XLEN'(4));

   a_r2_plain_restart: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && !st_level && !exc_in_slot |=> !cs_in_slot && ret_pc == $past(exc_pc));

   a_r8_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !st_boot |=> $stable(vec_base));

   a_r10_writes_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> st_boot == $past(st_boot) && cs_ivec == $past(cs_ivec));

endmodule

bind exc_vector_gen exc_vec_chk #(
   .XLEN   (XLEN),
   .CE_W   (CE_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .exc_req     (exc_req),
   .exc_type    (exc_type),
   .exc_pc      (exc_pc),
   .exc_in_slot (exc_in_slot),
   .exc_cop     (exc_cop),
   .ret_pc      (ret_pc),
   .cs_in_slot  (cs_in_slot),
   .cs_cop      (cs_cop),
   .cs_code     (cs_code),
   .cs_ivec     (cs_ivec),
   .st_level    (st_level),
   .st_boot     (st_boot),
   .vec_base    (vec_base),
   .redir_valid (redir_valid)
);

// File: tb/sim_exc_vector_gen.sv
`timescale 1ns/1ps
module sim_exc_vector_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0;
   logic [4:0]  exc_type = '0;
   logic        exc_refill = 1'b0;
   logic [31:0] exc_pc = '0;
   logic        exc_in_slot = 1'b0;
   logic [1:0]  exc_cop = '0;
   logic        st_wr_en = 1'b0;
   logic        st_wr_boot = 1'b0;
   logic        st_wr_level = 1'b0;
   logic        cs_wr_en = 1'b0;
   logic        cs_wr_ivec = 1'b0;
   logic        vb_wr_en = 1'b0;
   logic [31:0] vb_wr_data = '0;
   logic [31:0] ret_pc;
   logic        cs_in_slot;
   logic [1:0]  cs_cop;
   logic [4:0]  cs_code;
   logic        cs_ivec;
   logic        st_level;
   logic        st_boot;
   logic [31:0] vec_base;
   logic        redir_valid;
   logic [31:0] redir_pc;

   always #2.5 clk = ~clk;

   exc_vector_gen u0 (.*);

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic        boot;
      logic        ivec;
      logic        level;
      logic        refill;
      logic        slot;
      logic [4:0]  code;
      logic [1:0]  cop;
      logic [31:0] pc;
      logic [31:0] exp_pc;
   } vec_t;

   localparam int NV = 10;
   // vector base is programmed to 0x9234_5000 before the table runs
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd4,  2'd0, 32'h0040_0100, 32'hBFC0_0380},
      '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd2,  2'd1, 32'h0040_0200, 32'hBFC0_0200},
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  2'd0, 32'h0040_0300, 32'hBFC0_0400},
      '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  2'd0, 32'h0040_0400, 32'hBFC0_0380},
      '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd3,  2'd0, 32'h0040_1008, 32'h9234_5000},
      '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd2,  2'd2, 32'h0050_0000, 32'h9234_5180},
      '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  2'd2, 32'h0050_0010, 32'h9234_5200},
      '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd11, 2'd3, 32'h0050_0024, 32'h9234_5180},
      '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0,  2'd1, 32'h0060_0000, 32'hBFC0_0380},
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd8,  2'd0, 32'h0060_0040, 32'hBFC0_0380}
   };

   logic [31:0] m_ret = '0;
   logic        m_slot = 1'b0;

   task automatic fire(input logic [4:0] code, input logic refill, input logic slot,
                       input logic [1:0] cop, input logic [31:0] pc);
      exc_type = code; exc_refill = refill; exc_in_slot = slot;
      exc_cop = cop; exc_pc = pc; exc_req = 1'b1;
      @(negedge clk);
      exc_req = 1'b0;
   endtask

   task automatic set_state(input logic boot, input logic level, input logic ivec);
      st_wr_en = 1'b1; st_wr_boot = boot; st_wr_level = level;
      cs_wr_en = 1'b1; cs_wr_ivec = ivec;
      @(negedge clk);
      st_wr_en = 1'b0; cs_wr_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ret_pc", ret_pc, 32'h0);
      chk("R1 vec_base", vec_base, 32'h8000_0000);
      chk("R1 boot", {31'b0, st_boot}, 32'd1);
      chk("R1 level", {31'b0, st_level}, 32'd0);
      chk("R1 ivec", {31'b0, cs_ivec}, 32'd0);
      chk("R1 code", {27'b0, cs_code}, 32'd0);
      chk("R1 redir_valid", {31'b0, redir_valid}, 32'd0);

      // R8 program base while boot window active; only bits 29:12 stick
      vb_wr_en = 1'b1; vb_wr_data = 32'h1234_5ABC;
      @(negedge clk);
      vb_wr_en = 1'b0;
      chk("R8 base layout", vec_base, 32'h9234_5000);

      // table: R2 R3 R4 R5 R6 R7 R9
      for (int i = 0; i < NV; i++) begin
         set_state(VECS[i].boot, VECS[i].level, VECS[i].ivec);
         if (!VECS[i].level) begin
            m_ret  = VECS[i].slot ? VECS[i].pc - 32'd4 : VECS[i].pc;
            m_slot = VECS[i].slot;
         end
         fire(VECS[i].code, VECS[i].refill, VECS[i].slot, VECS[i].cop, VECS[i].pc);
         chk("R9 strobe", {31'b0, redir_valid}, 32'd1);
         chk("R5/R6 redir_pc", redir_pc, VECS[i].exp_pc);
         chk("R2/R3/R4 ret_pc", ret_pc, m_ret);
         chk("R2/R3/R4 slot", {31'b0, cs_in_slot}, {31'b0, m_slot});
         chk("R7 code", {27'b0, cs_code}, {27'b0, VECS[i].code});
         chk("R7 cop", {30'b0, cs_cop}, {30'b0, VECS[i].cop});
         chk("R7 level", {31'b0, st_level}, 32'd1);
         @(negedge clk);
         chk("R9 single pulse", {31'b0, redir_valid}, 32'd0);
      end

      // R8 write ignored under the programmable window
      set_state(1'b0, 1'b0, 1'b0);
      vb_wr_en = 1'b1; vb_wr_data = 32'h3FFF_F000;
      @(negedge clk);
      vb_wr_en = 1'b0;
      chk("R8 ignored write", vec_base, 32'h9234_5000);
      fire(5'd4, 1'b0, 1'b0, 2'd0, 32'h0070_0000);
      chk("R8 base used", redir_pc, 32'h9234_5180);

      // R8 all-ones write in boot window
      set_state(1'b1, 1'b0, 1'b0);
      vb_wr_en = 1'b1; vb_wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
      vb_wr_en = 1'b0;
      chk("R8 fixed bits", vec_base, 32'hBFFF_F000);

      // R10 writes racing an exception are dropped
      st_wr_en = 1'b1; st_wr_boot = 1'b0; st_wr_level = 1'b0;
      cs_wr_en = 1'b1; cs_wr_ivec = 1'b1;
      fire(5'd4, 1'b0, 1'b0, 2'd0, 32'h0070_0100);
      st_wr_en = 1'b0; cs_wr_en = 1'b0;
      chk("R10 boot kept", {31'b0, st_boot}, 32'd1);
      chk("R10 ivec kept", {31'b0, cs_ivec}, 32'd0);
      chk("R10 level set", {31'b0, st_level}, 32'd1);
      chk("R10 redir_pc", redir_pc, 32'hBFC0_0380);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule